// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in the execute stage of a five-stage in-order pipeline and decides, for each of the two ALU operands, where the operand value comes from. It looks at the two source register numbers of the instruction now in execute. It also looks at the destination register number and register-write flag held in each of the two later pipeline registers: the one between execute and memory, and the one between memory and writeback. From these it produces a 2-bit source select per operand.

A thin wrapper also holds the operand multiplexers. With the register file values, the memory-stage result and the writeback value as inputs, the operand values can be observed directly at the ports. The logic is purely combinational: no clock, no state.

The register file is assumed to write in the first half of a cycle and read in the second. A register written and read in the same cycle therefore already arrives through the register file path and needs no bypass.

Top module: `operand_forward`

## Requirements
- R1: When no bypass condition holds for an operand, its select is 2'b00 and the operand equals the register file value for that operand.
- R2: An operand whose source register equals the memory-stage destination, while the memory-stage write flag is 1 and that destination is not register 0, gets select 2'b10 and the memory-stage result.
- R3: An operand whose source register equals the writeback destination, while the writeback write flag is 1, that destination is not register 0 and the R2 condition for the same operand is false, gets select 2'b01 and the writeback value.
- R4: When both later stages match one operand, the newer producer (memory stage, select 2'b10) wins.
- R5: A destination of register 0 is never bypassed from either stage, even when the write flag is set and the source is also register 0.
- R6: A stage whose write flag is 0 is never bypassed from. If the memory stage matches but does not write, a writing, matching writeback stage supplies the operand.
- R7: Operand A is compared against the first source field (rs) and operand B against the second (rt). The two operands are resolved independently and may take different sources in the same cycle. Register numbers are 5 bits wide.
- R8: The select code 2'b11 never appears on either output.
- R9: Selects and operands depend only on the present inputs and follow any input change with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exSrcA | input | 5 | First source register (rs) of the instruction in execute |
| exSrcB | input | 5 | Second source register (rt) of the instruction in execute |
| memDest | input | 5 | Destination register held in the execute/memory register |
| memWriteEn | input | 1 | Register-write flag of the execute/memory register |
| wbDest | input | 5 | Destination register held in the memory/writeback register |
| wbWriteEn | input | 1 | Register-write flag of the memory/writeback register |
| rfValA | input | 32 | Register file read value for operand A |
| rfValB | input | 32 | Register file read value for operand B |
| memValue | input | 32 | Result held in the execute/memory register |
| wbValue | input | 32 | Value being written back |
| selA | output | 2 | Source select for operand A (00 file, 01 writeback, 10 memory stage) |
| selB | output | 2 | Source select for operand B |
| operandA | output | 32 | Selected value for operand A |
| operandB | output | 32 | Selected value for operand B |

## Verification
The bench aims at the three-writer chain, where both later stages hold the same destination. A design with the wrong priority would hand the ALU the stale writeback value. It also drives register 0 as destination with the write flag set. A selector that skips the zero test would bypass a value that the architecture discards. Further cases cover a matching stage with its write flag low, and a cycle in which A and B take different stages. These catch a design that ignores the flag, lets one operand's match suppress the other, or compares A and B against swapped fields. A long pseudo-random sweep over small register numbers makes matches frequent, so that mixed cases are compared against a model built from the rules alone.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WBACK   = 2'b01,
    SRC_MEMSTG  = 2'b10
  } fwd_src_e;

  localparam int NUM_OPERANDS = 2;

  typedef struct packed {
    logic [NUM_OPERANDS-1:0] takeMem;
    logic [NUM_OPERANDS-1:0] takeWb;
  } fwd_strobe_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic [NUM_OPERANDS-1:0][REG_ADDR_W-1:0] srcRegs,
  input  logic [REG_ADDR_W-1:0]                   memDest,
  input  logic                                    memWriteEn,
  input  logic [REG_ADDR_W-1:0]                   wbDest,
  input  logic                                    wbWriteEn,
  output fwd_strobe_t                             strobes,
  output logic [NUM_OPERANDS-1:0][1:0]            selCodes
);

  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  logic memLive;
  logic wbLive;

  // A stage can only feed an operand if it writes a real register.
  assign memLive = memWriteEn && (memDest != ZERO_REG);
  assign wbLive  = wbWriteEn  && (wbDest  != ZERO_REG);

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_opnd
    logic memHit;
    logic wbHit;

    assign memHit = memLive && (memDest == srcRegs[g]);
    // Older producer yields to the newer one on the same operand.
    assign wbHit  = wbLive && (wbDest == srcRegs[g]) && !memHit;

    assign strobes.takeMem[g] = memHit;
    assign strobes.takeWb[g]  = wbHit;

    always_comb begin
      if (memHit)     selCodes[g] = SRC_MEMSTG;
      else if (wbHit) selCodes[g] = SRC_WBACK;
      else            selCodes[g] = SRC_REGFILE;
    end
  end

endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_strobe_t                             strobes,
  input  logic [NUM_OPERANDS-1:0][DATA_W-1:0]     rfVals,
  input  logic [DATA_W-1:0]                       memValue,
  input  logic [DATA_W-1:0]                       wbValue,
  output logic [NUM_OPERANDS-1:0][DATA_W-1:0]     operands
);

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_mux
    always_comb begin
      if (strobes.takeMem[g])     operands[g] = memValue;
      else if (strobes.takeWb[g]) operands[g] = wbValue;
      else                        operands[g] = rfVals[g];
    end
  end

endmodule

// File: rtl/operand_forward.sv
module operand_forward
  import fwd_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int DATA_W     = 32
) (
  input  logic [REG_ADDR_W-1:0] exSrcA,
  input  logic [REG_ADDR_W-1:0] exSrcB,
  input  logic [REG_ADDR_W-1:0] memDest,
  input  logic                  memWriteEn,
  input  logic [REG_ADDR_W-1:0] wbDest,
  input  logic                  wbWriteEn,
  input  logic [DATA_W-1:0]     rfValA,
  input  logic [DATA_W-1:0]     rfValB,
  input  logic [DATA_W-1:0]     memValue,
  input  logic [DATA_W-1:0]     wbValue,
  output logic [1:0]            selA,
  output logic [1:0]            selB,
  output logic [DATA_W-1:0]     operandA,
  output logic [DATA_W-1:0]     operandB
);

  localparam int OP_A = 0;
  localparam int OP_B = 1;

  logic [NUM_OPERANDS-1:0][REG_ADDR_W-1:0] srcRegs;
  logic [NUM_OPERANDS-1:0][DATA_W-1:0]     rfVals;
  logic [NUM_OPERANDS-1:0][DATA_W-1:0]     operands;
  logic [NUM_OPERANDS-1:0][1:0]            selCodes;
  fwd_strobe_t                             strobes;

  assign srcRegs[OP_A] = exSrcA;
  assign srcRegs[OP_B] = exSrcB;
  assign rfVals[OP_A]  = rfValA;
  assign rfVals[OP_B]  = rfValB;

  fwd_match #(
    .REG_ADDR_W(REG_ADDR_W)
  ) u_match (
    .srcRegs    (srcRegs),
    .memDest    (memDest),
    .memWriteEn (memWriteEn),
    .wbDest     (wbDest),
    .wbWriteEn  (wbWriteEn),
    .strobes    (strobes),
    .selCodes   (selCodes)
  );

  fwd_operand_mux #(
    .DATA_W(DATA_W)
  ) u_mux (
    .strobes  (strobes),
    .rfVals   (rfVals),
    .memValue (memValue),
    .wbValue  (wbValue),
    .operands (operands)
  );

  assign selA     = selCodes[OP_A];
  assign selB     = selCodes[OP_B];
  assign operandA = operands[OP_A];
  assign operandB = operands[OP_B];

endmodule

// File: rtl/operand_forward_checker.sv
module operand_forward_checker #(
  parameter int REG_ADDR_W = 5,
  parameter int DATA_W     = 32
) (
  input logic [REG_ADDR_W-1:0] exSrcA,
  input logic [REG_ADDR_W-1:0] exSrcB,
  input logic [REG_ADDR_W-1:0] memDest,
  input logic                  memWriteEn,
  input logic [REG_ADDR_W-1:0] wbDest,
  input logic                  wbWriteEn,
  input logic [DATA_W-1:0]     memValue,
  input logic [DATA_W-1:0]     wbValue,
  input logic [1:0]            selA,
  input logic [1:0]            selB,
  input logic [DATA_W-1:0]     operandA,
  input logic [DATA_W-1:0]     operandB
);

  logic inputsKnown;
  assign inputsKnown = !$isunknown({exSrcA, exSrcB, memDest, memWriteEn,
                                    wbDest, wbWriteEn, selA, selB});

  always_comb begin
    if (inputsKnown) begin
      assert_no_code11_R8: assert (selA != 2'b11 && selB != 2'b11);
      assert_newer_wins_R4: assert (!(memWriteEn && memDest != '0 &&
                                      memDest == exSrcA) || selA == 2'b10);
      assert_mem_source_R2: assert (selB != 2'b10 ||
                                    (memWriteEn && memDest == exSrcB &&
                                     operandB == memValue));
      assert_wb_source_R3: assert (selA != 2'b01 ||
                                   (wbWriteEn && wbDest == exSrcA &&
                                    operandA == wbValue));
      assert_zero_dest_R5: assert (exSrcA != '0 || selA == 2'b00);
      assert_flag_low_R6: assert ((memWriteEn || selB != 2'b10) &&
                                  (wbWriteEn  || selB != 2'b01));
    end
  end

endmodule

bind operand_forward operand_forward_checker #(
  .REG_ADDR_W(REG_ADDR_W),
  .DATA_W    (DATA_W)
) u_checker (
  .exSrcA     (exSrcA),
  .exSrcB     (exSrcB),
  .memDest    (memDest),
  .memWriteEn (memWriteEn),
  .wbDest     (wbDest),
  .wbWriteEn  (wbWriteEn),
  .memValue   (memValue),
  .wbValue    (wbValue),
  .selA       (selA),
  .selB       (selB),
  .operandA   (operandA),
  .operandB   (operandB)
);

// File: tb/operand_forward_bench.sv
module operand_forward_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int WATCHDOG_CYCLES = 20000;

  typedef struct {
    logic [1:0]    selA;
    logic [1:0]    selB;
    logic [DW-1:0] opA;
    logic [DW-1:0] opB;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic [AW-1:0] exSrcA = '0, exSrcB = '0, memDest = '0, wbDest = '0;
  logic memWriteEn = 1'b0, wbWriteEn = 1'b0;
  logic [DW-1:0] rfValA = 32'hA0A0_0001, rfValB = 32'hB0B0_0002;
  logic [DW-1:0] memValue = 32'hC0C0_0003, wbValue = 32'hD0D0_0004;
  logic [1:0] selA, selB;
  logic [DW-1:0] operandA, operandB;

  exp_t scoreQ[$];
  int compared = 0;
  int mismatched = 0;
  bit driveDone = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_forward #(.REG_ADDR_W(AW), .DATA_W(DW)) u_operand_forward (
    .exSrcA(exSrcA), .exSrcB(exSrcB), .memDest(memDest),
    .memWriteEn(memWriteEn), .wbDest(wbDest), .wbWriteEn(wbWriteEn),
    .rfValA(rfValA), .rfValB(rfValB), .memValue(memValue),
    .wbValue(wbValue), .selA(selA), .selB(selB),
    .operandA(operandA), .operandB(operandB)
  );

  // Reference rule for one operand, from R2, R3, R5, R6.
  function automatic logic [1:0] refSel(input logic [AW-1:0] src);
    if (memWriteEn && memDest != 0 && memDest == src) return 2'b10;
    if (wbWriteEn && wbDest != 0 && wbDest == src)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] refVal(input logic [1:0] s,
                                           input logic [DW-1:0] rf);
    case (s)
      2'b10:   return memValue;
      2'b01:   return wbValue;
      default: return rf;
    endcase
  endfunction

  task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] b,
                       input logic [AW-1:0] md, input logic mw,
                       input logic [AW-1:0] wd, input logic ww,
                       input string tag);
    exp_t e;
    @(negedge clk);
    exSrcA = a; exSrcB = b; memDest = md; memWriteEn = mw;
    wbDest = wd; wbWriteEn = ww;
    rfValA = rfValA + 32'h11; rfValB = rfValB + 32'h13;
    memValue = memValue + 32'h17; wbValue = wbValue + 32'h1D;
    e.selA = refSel(a);
    e.selB = refSel(b);
    e.opA  = refVal(e.selA, rfValA);
    e.opB  = refVal(e.selB, rfValB);
    e.tag  = tag;
    scoreQ.push_back(e);
  endtask

  // Monitor: compares at the edge after each drive (inputs settled at negedge).
  initial begin
    forever begin
      @(posedge clk);
      if (scoreQ.size() > 0) begin
        exp_t e;
        e = scoreQ.pop_front();
        compared++;
        if (selA !== e.selA || selB !== e.selB ||
            operandA !== e.opA || operandB !== e.opB) begin
          mismatched++;
          $display("FAIL %s: selA=%b selB=%b opA=%h opB=%h expected selA=%b selB=%b opA=%h opB=%h",
                   e.tag, selA, selB, operandA, operandB,
                   e.selA, e.selB, e.opA, e.opB);
        end
      end
    end
  end

  initial begin
    // R1: idle inputs, nothing writes
    drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, "R1 start-up idle");
    drive(5'd3, 5'd4, 5'd7, 1'b1, 5'd8, 1'b1, "R1 no match");
    // R2: memory stage feeds A, then B
    drive(5'd5, 5'd9, 5'd5, 1'b1, 5'd0, 1'b0, "R2 mem to A");
    drive(5'd9, 5'd6, 5'd6, 1'b1, 5'd2, 1'b1, "R2 mem to B");
    // R3: writeback feeds B, then A
    drive(5'd1, 5'd12, 5'd3, 1'b1, 5'd12, 1'b1, "R3 wb to B");
    drive(5'd20, 5'd2, 5'd4, 1'b0, 5'd20, 1'b1, "R3 wb to A");
    // R4: chain writing the same register
    drive(5'd1, 5'd3, 5'd1, 1'b1, 5'd1, 1'b1, "R4 newer wins A");
    drive(5'd7, 5'd7, 5'd7, 1'b1, 5'd7, 1'b1, "R4 newer wins both");
    // R5: register zero destination
    drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, "R5 zero dest both stages");
    drive(5'd0, 5'd4, 5'd0, 1'b1, 5'd4, 1'b1, "R5 zero mem, wb feeds B");
    // R6: write flag low
    drive(5'd8, 5'd8, 5'd8, 1'b0, 5'd8, 1'b1, "R6 mem not writing, wb used");
    drive(5'd8, 5'd9, 5'd8, 1'b0, 5'd9, 1'b0, "R6 neither writing");
    // R7: independent operands, field mapping
    drive(5'd10, 5'd11, 5'd10, 1'b1, 5'd11, 1'b1, "R7 A mem B wb");
    drive(5'd11, 5'd10, 5'd10, 1'b1, 5'd11, 1'b1, "R7 A wb B mem");
    drive(5'd31, 5'd30, 5'd30, 1'b1, 5'd31, 1'b1, "R7 top register numbers");
    // R8, R9: pseudo-random sweep with small register numbers; each new
    // input set must be reflected with no clocked delay.
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        drive({3'b0, lfsr[1:0]}, {3'b0, lfsr[3:2]}, {3'b0, lfsr[5:4]},
              lfsr[6], {3'b0, lfsr[8:7]}, lfsr[9], "R8 R9 sweep");
      end
    end
    @(negedge clk);
    @(negedge clk);
    driveDone = 1'b1;
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES; c++) begin
      @(posedge clk);
      if (driveDone) break;
    end
    if (!driveDone) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule